// File: doc/BRIEF.md
# Secondary Interrupt Combiner with Direct Routing

This block collects 32 level-sensitive interrupt requests and presents them to a primary interrupt controller on 32 parent lines. The top parent line (line 31) is the combined request. It is high while any source that is currently high also has its enable bit set. A fixed window of sources, lines 21 to 30, can instead be routed one to one onto the parent lines of the same number. Each line of the window has its own routing enable bit. A routed line follows its source level directly and does not pass through the enable mask.

Software reaches the block through a simple word-addressed register port that decodes a 4 KB window. The enable mask and the routing enable register are never written directly. Each has a set register and a clear register, so no read-modify-write is needed. Software can read the raw source levels, the masked sources and both enable registers. A pair of soft registers set or clear enable bit 0 on any nonzero write. Reads return combinationally from the current state. Parent lines are registered: they reflect the state held after a clock edge one edge later.

Top module: `sic_irq_ctrl`

## Requirements
- R1: On every clock edge the raw level register captures `src_i`. Reading word 1 (byte address 0x004) returns the raw level. Reading word 0 (0x000) returns raw level AND enable mask.
- R2: `parent_o[31]` is high exactly when (raw level AND enable mask) was nonzero at the previous clock edge. An input change therefore appears two edges after it is applied, and a register write one edge after it takes effect.
- R3: Writing word 2 (0x008) ORs the written data into the enable mask. Reading word 2 returns the mask.
- R4: Writing word 3 (0x00C) clears each enable-mask bit that is 1 in the written data.
- R5: Writing a nonzero value to word 4 (0x010) sets mask bit 0. Writing a nonzero value to word 5 (0x014) clears mask bit 0. A zero write to either word changes nothing. Reading word 4 returns raw level bit 0 in bit 0 and zeros in bits 31 to 1.
- R6: Writing word 8 (0x020) ORs (data AND 0x7FE00000) into the routing enable register, so only bits 21 to 30 can ever be set. Reading word 8 returns the register.
- R7: Writing word 9 (0x024) clears each routing enable bit that is 1 in the written data.
- R8: For each n from 21 to 30, `parent_o[n]` equals raw bit n AND routing enable bit n as held after the previous edge. It is low while routing for that line is disabled.
- R9: `parent_o[20:0]` is always zero.
- R10: Reads of words other than 0, 1, 2, 4 and 8 return zero. Writes to words other than 2, 3, 4, 5, 8 and 9 change no state.
- R11: After reset the raw level, enable mask and routing enable are zero and all parent lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| bus_sel | input | 1 | Register access strobe, one cycle per write |
| bus_wr | input | 1 | Write when high together with `bus_sel` |
| bus_addr | input | 12 | Byte address in the register window; bits 11:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| parent_o | output | 32 | Lines toward the primary controller; bit 31 combined, bits 21 to 30 routed |

## Verification
A source level change and a register write can fall on the same clock edge. Both then feed the combined line and the routed lines one edge later. The stimulus table provokes this by raising source 30 in the same cycle as an enable-mask write that exposes it, while its routing bit is already set. It then checks that both parent line 30 and parent line 31 rise together on the next edge. A later entry clears routing while the source stays high and expects line 30 to drop while line 31 holds.

// File: rtl/sic_pkg.sv
package sic_pkg;

   // Word indices inside the register window (byte address >> 2)
   localparam int unsigned W_MASKED  = 0;
   localparam int unsigned W_RAW     = 1;
   localparam int unsigned W_EN_SET  = 2;
   localparam int unsigned W_EN_CLR  = 3;
   localparam int unsigned W_SOFT_SET = 4;
   localparam int unsigned W_SOFT_CLR = 5;
   localparam int unsigned W_RT_SET  = 8;
   localparam int unsigned W_RT_CLR  = 9;

   // One-hot write strobes produced by the decoder
   typedef struct packed {
      logic en_set;
      logic en_clr;
      logic soft_set;
      logic soft_clr;
      logic rt_set;
      logic rt_clr;
      logic undef;
   } wr_strobe_t;

   // Mask with ones from bit lo to bit hi inclusive
   function automatic logic [63:0] span_mask(input int unsigned lo, input int unsigned hi);
      logic [63:0] m;
      m = '0;
      for (int unsigned i = 0; i < 64; i++) begin
         if (i >= lo && i <= hi) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/sic_decode.sv
module sic_decode
   import sic_pkg::*;
#(
   parameter int unsigned NSRC   = 32,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NSRC-1:0]   raw_i,
   input  logic [NSRC-1:0]   mask_i,
   input  logic [NSRC-1:0]   rt_i,
   output wr_strobe_t        wstb_o,
   output logic [NSRC-1:0]   rdata_o
);

   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              wr_go;

   assign word  = bus_addr[ADDR_W-1:2];
   assign wr_go = bus_sel & bus_wr;

   always_comb begin
      wstb_o = '0;
      if (wr_go) begin
         case (word)
            WORD_W'(W_EN_SET):   wstb_o.en_set   = 1'b1;
            WORD_W'(W_EN_CLR):   wstb_o.en_clr   = 1'b1;
            WORD_W'(W_SOFT_SET): wstb_o.soft_set = 1'b1;
            WORD_W'(W_SOFT_CLR): wstb_o.soft_clr = 1'b1;
            WORD_W'(W_RT_SET):   wstb_o.rt_set   = 1'b1;
            WORD_W'(W_RT_CLR):   wstb_o.rt_clr   = 1'b1;
            default:             wstb_o.undef    = 1'b1;
         endcase
      end
   end

   always_comb begin
      case (word)
         WORD_W'(W_MASKED):   rdata_o = raw_i & mask_i;
         WORD_W'(W_RAW):      rdata_o = raw_i;
         WORD_W'(W_EN_SET):   rdata_o = mask_i;
         WORD_W'(W_SOFT_SET): rdata_o = {{(NSRC-1){1'b0}}, raw_i[0]};
         WORD_W'(W_RT_SET):   rdata_o = rt_i;
         default:             rdata_o = '0;
      endcase
   end

   // R10: at most one write strobe per cycle
   always_comb begin
      a_r10_one_strobe: assert ($onehot0(wstb_o));
   end

endmodule

// File: rtl/sic_regs.sv
module sic_regs
   import sic_pkg::*;
#(
   parameter int unsigned NSRC  = 32,
   parameter int unsigned RT_LO = 21,
   parameter int unsigned RT_HI = 30
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_i,
   input  wr_strobe_t      wstb_i,
   input  logic [NSRC-1:0] wdata_i,
   output logic [NSRC-1:0] raw_o,
   output logic [NSRC-1:0] mask_o,
   output logic [NSRC-1:0] rt_o
);

   localparam logic [NSRC-1:0] RT_WIN = NSRC'(span_mask(RT_LO, RT_HI));

   logic [NSRC-1:0] raw_q, mask_q, rt_q;
   logic [NSRC-1:0] mask_d, rt_d;
   logic            wnz;

   assign wnz = |wdata_i;

   always_comb begin
      mask_d = mask_q;
      if (wstb_i.en_set)           mask_d = mask_q | wdata_i;
      if (wstb_i.en_clr)           mask_d = mask_q & ~wdata_i;
      if (wstb_i.soft_set && wnz)  mask_d[0] = 1'b1;
      if (wstb_i.soft_clr && wnz)  mask_d[0] = 1'b0;
   end

   always_comb begin
      rt_d = rt_q;
      if (wstb_i.rt_set) rt_d = rt_q | (wdata_i & RT_WIN);
      if (wstb_i.rt_clr) rt_d = rt_q & ~wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         mask_q <= '0;
         rt_q   <= '0;
      end else begin
         raw_q  <= src_i;
         mask_q <= mask_d;
         rt_q   <= rt_d;
      end
   end

   assign raw_o  = raw_q;
   assign mask_o = mask_q;
   assign rt_o   = rt_q;

   a_r1_raw_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> raw_q == $past(src_i));

   a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
      wstb_i.en_set |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wstb_i.en_clr |=> ((mask_q & $past(wdata_i)) == '0));

   a_r5_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wstb_i.soft_set && wnz) |=> mask_q[0]);

   a_r5_soft_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (wstb_i.soft_clr && wnz) |=> !mask_q[0]);

   a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_q & ~RT_WIN) == '0);

   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wstb_i.rt_clr |=> ((rt_q & $past(wdata_i)) == '0));

   a_r10_undef_write: assert property (@(posedge clk) disable iff (!rst_n)
      wstb_i.undef |=> ($stable(mask_q) && $stable(rt_q)));

endmodule

// File: rtl/sic_outmux.sv
module sic_outmux #(
   parameter int unsigned NSRC     = 32,
   parameter int unsigned COMB_IDX = 31,
   parameter int unsigned RT_LO    = 21,
   parameter int unsigned RT_HI    = 30
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] raw_i,
   input  logic [NSRC-1:0] mask_i,
   input  logic [NSRC-1:0] rt_i,
   output logic [NSRC-1:0] parent_o
);

   logic any_pend;
   assign any_pend = |(raw_i & mask_i);

   for (genvar n = 0; n < NSRC; n++) begin : g_line
      if (n == COMB_IDX) begin : g_comb
         logic comb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) comb_q <= 1'b0;
            else        comb_q <= any_pend;
         end
         assign parent_o[n] = comb_q;

         a_r2_comb_rise: assert property (@(posedge clk) disable iff (!rst_n)
            any_pend |=> parent_o[n]);
         a_r2_comb_fall: assert property (@(posedge clk) disable iff (!rst_n)
            !any_pend |=> !parent_o[n]);
      end else if (n >= RT_LO && n <= RT_HI) begin : g_route
         logic rt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rt_q <= 1'b0;
            else        rt_q <= raw_i[n] & rt_i[n];
         end
         assign parent_o[n] = rt_q;

         a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
            !rt_i[n] |=> !parent_o[n]);
         a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (rt_i[n] && raw_i[n]) |=> parent_o[n]);
      end else begin : g_tie
         assign parent_o[n] = 1'b0;
      end
   end

endmodule

// File: rtl/sic_irq_ctrl.sv
module sic_irq_ctrl
   import sic_pkg::*;
#(
   parameter int unsigned NSRC     = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned COMB_IDX = 31,
   parameter int unsigned RT_LO    = 21,
   parameter int unsigned RT_HI    = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NSRC-1:0]   bus_wdata,
   output logic [NSRC-1:0]   bus_rdata,
   output logic [NSRC-1:0]   parent_o
);

   localparam int unsigned MIN_ADDR_W = 6;

   if (NSRC > 64 || NSRC < 2) begin : g_chk_n
      $error("sic_irq_ctrl: NSRC out of range");
   end
   if (RT_LO > RT_HI || RT_HI >= NSRC) begin : g_chk_win
      $error("sic_irq_ctrl: routing window invalid");
   end
   if (COMB_IDX >= NSRC || (COMB_IDX >= RT_LO && COMB_IDX <= RT_HI)) begin : g_chk_comb
      $error("sic_irq_ctrl: combined line overlaps window");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_chk_addr
      $error("sic_irq_ctrl: address too narrow");
   end

   wr_strobe_t      wstb;
   logic [NSRC-1:0] raw, mask, rt;

   sic_decode #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_dec (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .raw_i   (raw),
      .mask_i  (mask),
      .rt_i    (rt),
      .wstb_o  (wstb),
      .rdata_o (bus_rdata)
   );

   sic_regs #(.NSRC(NSRC), .RT_LO(RT_LO), .RT_HI(RT_HI)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .wstb_i (wstb),
      .wdata_i(bus_wdata),
      .raw_o  (raw),
      .mask_o (mask),
      .rt_o   (rt)
   );

   sic_outmux #(.NSRC(NSRC), .COMB_IDX(COMB_IDX), .RT_LO(RT_LO), .RT_HI(RT_HI)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (raw),
      .mask_i  (mask),
      .rt_i    (rt),
      .parent_o(parent_o)
   );

   // R9 / R6: a parent line outside the combined line and the window never rises
   a_r9_low_lines: assert property (@(posedge clk) disable iff (!rst_n)
      (parent_o & ~(NSRC'(span_mask(RT_LO, RT_HI)) | (NSRC'(1) << COMB_IDX))) == '0);

endmodule

// File: tb/sic_irq_ctrl_test.sv
module sic_irq_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 12;

   typedef struct packed {
      logic        wr;
      logic [9:0]  wword;
      logic [31:0] wdata;
      logic [31:0] src;
      logic [31:0] exp_par;
      logic [9:0]  rword;
      logic [31:0] exp_rd;
   } vec_t;

   // wr, write word, data, sources, expected parent, read word, expected read
   localparam vec_t TBL [NV] = '{
      '{1'b1, 10'd2,  32'h0000_0010, 32'h0000_0000, 32'h0000_0000, 10'd2, 32'h0000_0010}, // R3 set
      '{1'b1, 10'd6,  32'hFFFF_FFFF, 32'h0000_0010, 32'h8000_0000, 10'd0, 32'h0000_0010}, // R1 R2 R10
      '{1'b1, 10'd3,  32'h0000_0010, 32'h0000_0010, 32'h0000_0000, 10'd1, 32'h0000_0010}, // R4 clear
      '{1'b1, 10'd8,  32'hFFFF_FFFF, 32'h0000_0010, 32'h0000_0000, 10'd8, 32'h7FE0_0000}, // R6 window
      '{1'b1, 10'd7,  32'h0000_0001, 32'hFFFF_FFFF, 32'h7FE0_0000, 10'd1, 32'hFFFF_FFFF}, // R8 R9
      '{1'b1, 10'd9,  32'h0020_0000, 32'hFFFF_FFFF, 32'h7FC0_0000, 10'd8, 32'h7FC0_0000}, // R7
      '{1'b1, 10'd4,  32'h0000_0005, 32'h0000_0001, 32'h8000_0000, 10'd4, 32'h0000_0001}, // R5 soft set
      '{1'b1, 10'd5,  32'h0000_0000, 32'h0000_0001, 32'h8000_0000, 10'd2, 32'h0000_0001}, // R5 zero write
      '{1'b1, 10'd5,  32'h0000_0100, 32'h0000_0001, 32'h0000_0000, 10'd0, 32'h0000_0000}, // R5 soft clear
      '{1'b1, 10'd2,  32'hC000_0000, 32'h4000_0000, 32'hC000_0000, 10'd0, 32'h4000_0000}, // R2 R8 same cycle
      '{1'b1, 10'd9,  32'hFFFF_FFFF, 32'h4000_0000, 32'h8000_0000, 10'd8, 32'h0000_0000}, // R7 R8 off low
      '{1'b1, 10'd10, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 10'd3, 32'h0000_0000}  // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] parent_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sic_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .parent_o(parent_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic string read_req(input logic [9:0] w);
      case (w)
         10'd0, 10'd1: return "R1 read";
         10'd2:        return "R3 read";
         10'd4:        return "R5 read";
         10'd8:        return "R6 read";
         default:      return "R10 read";
      endcase
   endfunction

   task automatic read_word(input logic [9:0] w, output logic [31:0] d);
      bus_addr = {w, 2'b00};
      #1;
      d = bus_rdata;
   endtask

   // Drive a write and sources before edge A; parent updates at edge B
   task automatic step(input vec_t v);
      logic [31:0] rd;
      @(negedge clk);
      src_i     = v.src;
      bus_sel   = v.wr;
      bus_wr    = v.wr;
      bus_addr  = {v.wword, 2'b00};
      bus_wdata = v.wdata;
      @(negedge clk);
      bus_sel = 1'b0;
      bus_wr  = 1'b0;
      @(negedge clk);
      check("R2 R8 R9 parent", parent_o, v.exp_par);
      read_word(v.rword, rd);
      check(read_req(v.rword), rd, v.exp_rd);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      src_i = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      // R11: reset state, sources high but held in reset
      check("R11 parent", parent_o, 32'h0);
      read_word(10'd1, rd); check("R11 raw", rd, 32'h0);
      read_word(10'd2, rd); check("R11 mask", rd, 32'h0);
      read_word(10'd8, rd); check("R11 route", rd, 32'h0);
      src_i = '0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) step(TBL[i]);

      // R2 latency: input change visible after two edges, not one
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h0000_0100;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      src_i = 32'h0000_0100;
      @(negedge clk);
      check("R2 latency one edge", parent_o, 32'h0);
      @(negedge clk);
      check("R2 latency two edges", parent_o, 32'h8000_0000);

      // R9: low lines stay low with everything enabled
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h008; bus_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      bus_addr = 12'h020;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      src_i = 32'hFFFF_FFFF;
      repeat (2) @(negedge clk);
      check("R9 all enabled", parent_o, 32'hFFE0_0000);

      // R11: reset mid-run clears everything
      rst_n = 1'b0;
      #1;
      check("R11 async reset parent", parent_o, 32'h0);
      read_word(10'd2, rd); check("R11 async reset mask", rd, 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule